// File: doc/BRIEF.md
# Millisecond Clock With Interval Interrupts

This block is a real-time clock peripheral that sits on a minicomputer I/O bus. A one-cycle tick-enable pulse, arriving once per millisecond from a prescaler outside the block, advances a 16-bit count that runs from 0 to 59999. When the count would reach 60000, one full minute has passed. The count then returns to zero and a minute interrupt request is raised.

A second interrupt request is raised every time the count lands on a multiple of 32, so it fires every 32 milliseconds. The wrap to zero counts as landing on such a multiple. Each request is a single-cycle pulse. Each request source has its own 4-bit priority level, which software writes through a configuration strobe, and that level is presented beside the request. The processor reads the live count with an I/O read strobe.

When the device is switched off, the count freezes and no requests are produced. An I/O read addressed to the switched-off device is flagged as an illegal instruction and returns no data.

Top module: `msclk_top`

## Requirements
- R1: A cycle with `tick_en` high and `dev_enable` high raises the count by one. The new value is visible from the next clock edge. In every other cycle the count keeps its value.
- R2: The count never leaves the range 0 to 59999. A tick taken at 59999 loads 0 instead of 60000.
- R3: The tick that loads 0 from 59999 makes `irq_minute` high for exactly one cycle, in the cycle right after that tick's clock edge. No other tick raises `irq_minute`.
- R4: A tick whose resulting count (taking the wrap as 60000) is a multiple of 32 makes `irq_frame` high for exactly one cycle, timed as in R3. On the wrap, `irq_frame` and `irq_minute` are high in the same cycle.
- R5: A cycle with `cfg_we` high stores `cfg_level` into the level of one source. `cfg_sel` = 0 selects the 32 ms source, shown on `lvl_frame`. `cfg_sel` = 1 selects the minute source, shown on `lvl_minute`. The new level shows from the next edge, the other level is not changed, and writes are accepted whether or not the device is enabled.
- R6: While `io_rd` is high and `dev_enable` is high, `io_data` equals the current count in the same cycle and `io_illegal` is 0. While `io_rd` is high and `dev_enable` is low, `io_illegal` is 1 and `io_data` is 0.
- R7: While `dev_enable` is low, ticks are ignored: the count does not move, and neither request is raised in the following cycle.
- R8: While `rst_n` is low, the count is 0, both requests are low and both levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle millisecond tick |
| dev_enable | input | 1 | Device active when high |
| io_rd | input | 1 | I/O read instruction strobe |
| io_data | output | 16 | Live count during a legal read, else 0 |
| io_illegal | output | 1 | Read addressed to a disabled device |
| cfg_we | input | 1 | Level write strobe |
| cfg_sel | input | 1 | Level select: 0 = 32 ms source, 1 = minute source |
| cfg_level | input | 4 | Level value to write |
| irq_frame | output | 1 | 32 ms request pulse |
| lvl_frame | output | 4 | Priority level of the 32 ms source |
| irq_minute | output | 1 | Minute request pulse |
| lvl_minute | output | 4 | Priority level of the minute source |

## Verification
The assertions assume a synchronous reset is applied before anything else happens. They also assume the control inputs are clean 0/1 values that change only between edges, and that the tick is a plain level sampled at each edge, with no assumption about how often it comes. The stimulus changes every input on the falling edge only. It pulses the tick in bursts, gaps and back-to-back runs that carry the count across a full minute. It switches the device off during ticks and during level writes, so that every input combination the properties depend on is reached without ever leaving that envelope.

// File: rtl/msclk_pkg.sv
package msclk_pkg;
   localparam int NUM_SRC    = 2;
   localparam int SEL_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int SRC_FRAME  = 0;
   localparam int SRC_MINUTE = 1;
endpackage

// File: rtl/msclk_counter.sv
module msclk_counter #(
   parameter int CNT_W      = 16,
   parameter int WRAP_COUNT = 60000,
   parameter int FRAME_LOG2 = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [CNT_W-1:0] count,
   output logic             frame_hit,
   output logic             minute_hit
);
   localparam int NXT_W = CNT_W + 1;
   localparam logic [NXT_W-1:0] WRAP_V = NXT_W'(WRAP_COUNT);

   logic [NXT_W-1:0] nxt;
   logic             wrap_now;
   logic             frame_now;

   assign nxt = {1'b0, count} + NXT_W'(1);

   generate
      if (WRAP_COUNT == (1 << CNT_W)) begin : g_wrap_carry
         assign wrap_now = nxt[CNT_W];
      end else begin : g_wrap_cmp
         assign wrap_now = (nxt == WRAP_V);
      end
   endgenerate

   assign frame_now = (nxt[FRAME_LOG2-1:0] == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count      <= '0;
         frame_hit  <= 1'b0;
         minute_hit <= 1'b0;
      end else begin
         frame_hit  <= 1'b0;
         minute_hit <= 1'b0;
         if (adv) begin
            count      <= wrap_now ? '0 : nxt[CNT_W-1:0];
            frame_hit  <= frame_now;
            minute_hit <= wrap_now;
         end
      end
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, count} < WRAP_V); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(count) && !frame_hit && !minute_hit); // R1
   AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (count == $past(count) + CNT_W'(1)) || (count == '0 && minute_hit)); // R1
   AST_MIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      minute_hit |-> count == '0); // R3
   AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      frame_hit |-> count[FRAME_LOG2-1:0] == '0); // R4
endmodule

// File: rtl/msclk_levels.sv
module msclk_levels
   import msclk_pkg::*;
#(
   parameter int LVL_W = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [SEL_W-1:0]              sel,
   input  logic [LVL_W-1:0]              data,
   output logic [NUM_SRC-1:0][LVL_W-1:0] levels
);
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               levels[i] <= '0;
            end else if (we && sel == SEL_W'(i)) begin
               levels[i] <= data;
            end
         end

         AST_LVL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (we && sel == SEL_W'(i)) |=> levels[i] == $past(data)); // R5
         AST_LVL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && sel == SEL_W'(i)) |=> $stable(levels[i])); // R5
      end
   endgenerate
endmodule

// File: rtl/msclk_io_port.sv
module msclk_io_port #(
   parameter int CNT_W = 16
) (
   input  logic             rd,
   input  logic             enable,
   input  logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] data,
   output logic             illegal
);
   always_comb begin
      data    = '0;
      illegal = 1'b0;
      if (rd) begin
         if (enable) data = count;
         else        illegal = 1'b1;
      end
   end
endmodule

// File: rtl/msclk_top.sv
module msclk_top
   import msclk_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int WRAP_COUNT = 60000,
   parameter int FRAME_LOG2 = 5,
   parameter int LVL_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             dev_enable,
   input  logic             io_rd,
   output logic [CNT_W-1:0] io_data,
   output logic             io_illegal,
   input  logic             cfg_we,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic [LVL_W-1:0] cfg_level,
   output logic             irq_frame,
   output logic [LVL_W-1:0] lvl_frame,
   output logic             irq_minute,
   output logic [LVL_W-1:0] lvl_minute
);
   localparam bit WRAP_ALIGNED = (WRAP_COUNT % (1 << FRAME_LOG2)) == 0;

   initial begin : elab_chk
      if (CNT_W < 2 || CNT_W > 30)
         $error("msclk_top: CNT_W out of range");
      if (WRAP_COUNT < 2 || WRAP_COUNT > (1 << CNT_W))
         $error("msclk_top: WRAP_COUNT does not fit the counter");
      if (FRAME_LOG2 < 1 || FRAME_LOG2 >= CNT_W)
         $error("msclk_top: FRAME_LOG2 out of range");
      if (LVL_W < 1)
         $error("msclk_top: LVL_W must be positive");
   end

   logic                          adv;
   logic [CNT_W-1:0]              count;
   logic [NUM_SRC-1:0][LVL_W-1:0] levels;

   assign adv = tick_en && dev_enable;

   msclk_counter #(
      .CNT_W(CNT_W), .WRAP_COUNT(WRAP_COUNT), .FRAME_LOG2(FRAME_LOG2)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .adv(adv), .count(count),
      .frame_hit(irq_frame), .minute_hit(irq_minute)
   );

   msclk_levels #(.LVL_W(LVL_W)) u_lvl (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
      .data(cfg_level), .levels(levels)
   );

   msclk_io_port #(.CNT_W(CNT_W)) u_io (
      .rd(io_rd), .enable(dev_enable), .count(count),
      .data(io_data), .illegal(io_illegal)
   );

   assign lvl_frame  = levels[SRC_FRAME];
   assign lvl_minute = levels[SRC_MINUTE];

   AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_enable |=> $stable(count) && !irq_frame && !irq_minute); // R7
   AST_READ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && dev_enable) |-> (io_data == count && !io_illegal)); // R6
   AST_READ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !dev_enable) |-> (io_illegal && io_data == '0)); // R6

   generate
      if (WRAP_ALIGNED) begin : g_both_chk
         AST_WRAP_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
            irq_minute |-> irq_frame); // R4
      end
   endgenerate
endmodule

// File: tb/sim_msclk_top.sv
`timescale 1ns/1ps
module sim_msclk_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        tick_en, dev_enable, io_rd, cfg_we;
   logic [0:0]  cfg_sel;
   logic [3:0]  cfg_level;
   logic [15:0] io_data;
   logic        io_illegal, irq_frame, irq_minute;
   logic [3:0]  lvl_frame, lvl_minute;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   typedef struct {
      logic [15:0] data;
      logic        chk_data;
      logic        ill, fr, mn;
      logic [3:0]  lf, lm;
      string       tag;
   } exp_t;
   exp_t q[$];

   int         m_cnt = 0;
   logic [3:0] m_lf = 4'd0;
   logic [3:0] m_lm = 4'd0;

   always #2.5 clk = ~clk;

   msclk_top u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dev_enable(dev_enable),
      .io_rd(io_rd), .io_data(io_data), .io_illegal(io_illegal),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_level(cfg_level),
      .irq_frame(irq_frame), .lvl_frame(lvl_frame),
      .irq_minute(irq_minute), .lvl_minute(lvl_minute)
   );

   task automatic chk(input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and queues the expected result
   task automatic step(input bit t, input bit en, input bit rd, input bit we,
                       input bit sel, input logic [3:0] lv, input string tag);
      exp_t e;
      @(negedge clk);
      tick_en = t; dev_enable = en; io_rd = rd;
      cfg_we = we; cfg_sel = sel; cfg_level = lv;
      e.fr = 1'b0; e.mn = 1'b0;
      if (t && en) begin
         m_cnt++;
         if (m_cnt % 32 == 0) e.fr = 1'b1;
         if (m_cnt == 60000) begin m_cnt = 0; e.mn = 1'b1; end
      end
      if (we) begin
         if (sel) m_lm = lv; else m_lf = lv;
      end
      e.data     = (rd && en) ? 16'(m_cnt) : 16'd0;
      e.chk_data = rd;
      e.ill      = rd && !en;
      e.lf       = m_lf;
      e.lm       = m_lm;
      e.tag      = tag;
      q.push_back(e);
   endtask

   // monitor: compares each queued item just after the edge it belongs to
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (e.chk_data) begin
               chk(e.tag, "io_data", io_data, e.data);
               chk(e.tag == "R7" ? "R6" : e.tag, "io_illegal",
                   16'(io_illegal), 16'(e.ill));
            end
            chk(e.tag, "irq_frame",  16'(irq_frame),  16'(e.fr));
            chk(e.tag, "irq_minute", 16'(irq_minute), 16'(e.mn));
            chk(e.tag, "lvl_frame",  16'(lvl_frame),  16'(e.lf));
            chk(e.tag, "lvl_minute", 16'(lvl_minute), 16'(e.lm));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; tick_en = 1'b1; dev_enable = 1'b1; io_rd = 1'b1;
      cfg_we = 1'b1; cfg_sel = 1'b0; cfg_level = 4'd7;
      repeat (3) @(posedge clk);
      #1;
      // R8: reset state, even with tick and write strobes high
      chk("R8", "io_data",    io_data,            16'd0);
      chk("R8", "irq_frame",  16'(irq_frame),     16'd0);
      chk("R8", "irq_minute", 16'(irq_minute),    16'd0);
      chk("R8", "lvl_frame",  16'(lvl_frame),     16'd0);
      chk("R8", "lvl_minute", 16'(lvl_minute),    16'd0);
      @(negedge clk);
      rst_n = 1'b1; tick_en = 1'b0; cfg_we = 1'b0;

      // R5: program both levels
      step(0, 1, 1, 1, 0, 4'd5,  "R5");
      step(0, 1, 1, 1, 1, 4'd12, "R5");
      // R1: back-to-back ticks up to the first 32 ms boundary (R4)
      for (int i = 0; i < 31; i++) step(1, 1, 1, 0, 0, 4'd0, "R1");
      step(1, 1, 1, 0, 0, 4'd0, "R4");
      // R1: idle cycles hold the count
      for (int i = 0; i < 3; i++) step(0, 1, 1, 0, 0, 4'd0, "R1");
      // R7: ticks while disabled are ignored; reads are illegal
      for (int i = 0; i < 5; i++) step(1, 0, 1, 0, 0, 4'd0, "R7");
      step(1, 0, 1, 1, 0, 4'd9, "R5");
      step(0, 1, 1, 0, 0, 4'd0, "R7");
      // R1: alternating ticks, with a level write riding on a tick
      for (int i = 0; i < 64; i++) step(i % 2 == 0, 1, 1, 0, 0, 4'd0, "R1");
      step(1, 1, 1, 1, 1, 4'd3, "R5");
      // R6: a cycle without read strobe, then live reads again
      step(1, 1, 0, 0, 0, 4'd0, "R6");
      // R2: run up to 59999
      while (m_cnt != 59999) step(1, 1, 1, 0, 0, 4'd0, "R2");
      step(0, 1, 1, 0, 0, 4'd0, "R2");
      // R3: the wrap tick raises both requests together
      step(1, 1, 1, 0, 0, 4'd0, "R3");
      for (int i = 0; i < 40; i++) step(1, 1, 1, 0, 0, 4'd0, "R4");
      step(0, 1, 1, 0, 0, 4'd0, "R4");
      while (q.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule